// File: doc/BRIEF.md
# Cumulative Charge Deviation Detector

This block screens a die for hidden extra circuitry by watching its supply charge build up over a test run. It runs in a test-per-clock flow. In every cycle it may take one pair of digitized values: the integrated current area measured on the die under test, and the worst-case area recorded for the same pattern on known-good dies. It keeps a running total of each stream. After every accepted pair it subtracts the reference total from the measured total and compares the result with a programmable threshold.

A gross deviation crosses the threshold within a few patterns. A slight deviation of a few counts per pattern keeps adding up and crosses it much later. When the threshold is crossed, the block stops, raises a detection flag and records which pattern caused it. If a programmed number of patterns passes without a crossing, it reports a clean finish instead. Two controls drive a run. Start arms a fresh run. Clear returns the block to idle.

Top module: `charge_dev_detector`

## Requirements
- R1: A pair is accepted only in a cycle where busy_o is high and sample_valid_i is high. An accepted pair adds meas_i to the measured total and ref_i to the reference total, at most one pair per clock. Pairs offered while busy_o is low, or with sample_valid_i low, change nothing.
- R2: At the clock edge that accepts a pair, the block forms the updated measured total minus the updated reference total as a signed value. If that value is strictly greater than threshold_i, detected_o goes high after that same edge. A zero, equal or negative difference never sets detected_o.
- R3: Each total is SAMPLE_W+HEADROOM bits wide. A sum that would pass all-ones is held at all-ones instead. In the same edge overflow_o goes high, and it stays high until start or clear.
- R4: When detection fires, det_index_o captures the 0-based count of pairs accepted before the triggering pair, and busy_o drops. detected_o and det_index_o then hold, and later pairs are ignored, until start or clear.
- R5: When the accepted count reaches a non-zero pattern_total_i without a detection, done_o goes high and busy_o drops. If detection fires on that last pair, detected_o is set and done_o is not. A pattern_total_i of zero means the run has no length limit.
- R6: A cycle with clear_i high zeroes both totals, the pattern count, det_index_o and all flags, and leaves busy_o low. clear_i takes priority over start_i.
- R7: A cycle with start_i high and clear_i low zeroes both totals, the count and all flags, and raises busy_o.
- R8: After reset, busy_o, detected_o, done_o and overflow_o are low and det_index_o is zero.
- R9: At most one of busy_o, detected_o and done_o is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| clear_i | input | 1 | Return to idle and zero all state |
| start_i | input | 1 | Zero all state and arm a run |
| sample_valid_i | input | 1 | The sample pair on meas_i and ref_i is present |
| meas_i | input | SAMPLE_W | Measured charge area for one pattern |
| ref_i | input | SAMPLE_W | Worst-case reference charge area for the same pattern |
| threshold_i | input | SAMPLE_W+HEADROOM | Allowed cumulative excess |
| pattern_total_i | input | CNT_W | Run length in patterns; zero means no limit |
| busy_o | output | 1 | A run is in progress |
| detected_o | output | 1 | Sticky deviation flag |
| done_o | output | 1 | The run ended without a detection |
| overflow_o | output | 1 | Sticky flag: a total saturated |
| det_index_o | output | CNT_W | 0-based index of the pattern that triggered detection |

## Verification
The bench drives a difference that lands exactly on the threshold, and one that goes negative and then recovers. A design with a non-strict or unsigned compare would flag one of these early. It runs a slow deviation of one count per pattern and expects detection at a precise index, which exposes an off-by-one in the index or a compare made on the pre-update totals. It pushes the measured total past full scale and then checks that a threshold one below all-ones still detects, which a wrapping accumulator would miss. It also fires detection on the last programmed pattern, raises start and clear in the same cycle, and offers pairs while idle. A design with the wrong priority, or one that keeps accumulating, shows up as a wrong flag.

// File: rtl/chg_pkg.sv
package chg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HIT  = 2'd2,
    ST_DONE = 2'd3
  } run_st_e;

endpackage

// File: rtl/chg_rst_sync.sv
module chg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/chg_accum.sv
module chg_accum #(
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 28
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                en_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [ACC_W-1:0]    sum_next_o,
  output logic                sat_o
);

  localparam int EXT_W = ACC_W + 1;

  logic [ACC_W-1:0] sum_q, sum_d;
  logic             sat_q, sat_d;
  logic [EXT_W-1:0] raw;
  logic             carry;

  // saturating add of the incoming sample
  always_comb begin
    raw        = {1'b0, sum_q} + EXT_W'(sample_i);
    carry      = raw[ACC_W];
    sum_next_o = carry ? {ACC_W{1'b1}} : raw[ACC_W-1:0];
  end

  always_comb begin
    sum_d = sum_q;
    sat_d = sat_q;
    if (clr_i) begin
      sum_d = '0;
      sat_d = 1'b0;
    end else if (en_i) begin
      sum_d = sum_next_o;
      sat_d = sat_q | carry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      sat_q <= 1'b0;
    end else begin
      sum_q <= sum_d;
      sat_q <= sat_d;
    end
  end

  assign sat_o = sat_q;

endmodule

// File: rtl/chg_cmp.sv
module chg_cmp #(
  parameter int ACC_W = 28
) (
  input  logic [ACC_W-1:0] meas_sum_i,
  input  logic [ACC_W-1:0] ref_sum_i,
  input  logic [ACC_W-1:0] thr_i,
  output logic             exceed_o
);

  logic signed [ACC_W+1:0] diff;
  logic signed [ACC_W+1:0] limit;

  always_comb begin
    diff     = $signed({2'b00, meas_sum_i}) - $signed({2'b00, ref_sum_i});
    limit    = $signed({2'b00, thr_i});
    exceed_o = diff > limit;
  end

endmodule

// File: rtl/chg_ctrl.sv
module chg_ctrl
  import chg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             start_i,
  input  logic             valid_i,
  input  logic             exceed_i,
  input  logic [CNT_W-1:0] total_i,
  output logic             accept_o,
  output run_st_e          state_o,
  output logic [CNT_W-1:0] idx_o
);

  run_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [CNT_W:0]   cnt_inc;
  logic             last_pat;

  assign accept_o = (st_q == ST_RUN) & valid_i & ~clear_i & ~start_i;

  always_comb begin
    cnt_inc  = {1'b0, cnt_q} + 1'b1;
    last_pat = (total_i != '0) && (cnt_inc == {1'b0, total_i});
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    if (clear_i) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
      idx_d = '0;
    end else if (start_i) begin
      st_d  = ST_RUN;
      cnt_d = '0;
      idx_d = '0;
    end else if (accept_o) begin
      if (cnt_q != {CNT_W{1'b1}}) cnt_d = cnt_inc[CNT_W-1:0];
      if (exceed_i) begin
        st_d  = ST_HIT;
        idx_d = cnt_q;
      end else if (last_pat) begin
        st_d = ST_DONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  assign state_o = st_q;
  assign idx_o   = idx_q;

endmodule

// File: rtl/charge_dev_detector.sv
module charge_dev_detector
  import chg_pkg::*;
#(
  parameter int SAMPLE_W   = 12,
  parameter int HEADROOM   = 16,
  parameter int CNT_W      = 16,
  localparam int ACC_W     = SAMPLE_W + HEADROOM
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear_i,
  input  logic                start_i,
  input  logic                sample_valid_i,
  input  logic [SAMPLE_W-1:0] meas_i,
  input  logic [SAMPLE_W-1:0] ref_i,
  input  logic [ACC_W-1:0]    threshold_i,
  input  logic [CNT_W-1:0]    pattern_total_i,
  output logic                busy_o,
  output logic                detected_o,
  output logic                done_o,
  output logic                overflow_o,
  output logic [CNT_W-1:0]    det_index_o
);

  localparam int NCH = 2;

  logic                rst_q_n;
  logic                accept;
  logic                acc_clr;
  logic                exceed;
  run_st_e             state;
  logic [SAMPLE_W-1:0] samp   [NCH];
  logic [ACC_W-1:0]    nxt    [NCH];
  logic                sat    [NCH];

  chg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  assign samp[0] = meas_i;
  assign samp[1] = ref_i;
  assign acc_clr = clear_i | start_i;

  // channel 0 measured, channel 1 golden reference
  for (genvar g = 0; g < NCH; g++) begin : g_acc
    chg_accum #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_acc (
      .clk        (clk),
      .rst_n      (rst_q_n),
      .clr_i      (acc_clr),
      .en_i       (accept),
      .sample_i   (samp[g]),
      .sum_next_o (nxt[g]),
      .sat_o      (sat[g])
    );
  end

  chg_cmp #(.ACC_W(ACC_W)) u_cmp (
    .meas_sum_i (nxt[0]),
    .ref_sum_i  (nxt[1]),
    .thr_i      (threshold_i),
    .exceed_o   (exceed)
  );

  chg_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .clear_i  (clear_i),
    .start_i  (start_i),
    .valid_i  (sample_valid_i),
    .exceed_i (exceed),
    .total_i  (pattern_total_i),
    .accept_o (accept),
    .state_o  (state),
    .idx_o    (det_index_o)
  );

  assign busy_o     = (state == ST_RUN);
  assign detected_o = (state == ST_HIT);
  assign done_o     = (state == ST_DONE);
  assign overflow_o = sat[0] | sat[1];

endmodule

// File: rtl/chg_checker.sv
module chg_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear_i,
  input logic             start_i,
  input logic             busy_o,
  input logic             detected_o,
  input logic             done_o,
  input logic             overflow_o,
  input logic [CNT_W-1:0] det_index_o
);

  assert_status_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy_o, detected_o, done_o}));

  assert_clear_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!busy_o && !detected_o && !done_o && !overflow_o));

  assert_start_arms_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !clear_i) |=> (busy_o && !detected_o && !done_o && !overflow_o));

  assert_hit_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (detected_o && !clear_i && !start_i) |=> (detected_o && $stable(det_index_o)));

  assert_no_overflow_loss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_o && !clear_i && !start_i) |=> overflow_o);

  assert_done_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !clear_i && !start_i) |=> done_o);

  assert_idle_stays_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !clear_i && !start_i) |=> !busy_o);

endmodule

bind charge_dev_detector chg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .clear_i     (clear_i),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .detected_o  (detected_o),
  .done_o      (done_o),
  .overflow_o  (overflow_o),
  .det_index_o (det_index_o)
);

// File: tb/test_charge_dev_detector.sv
module test_charge_dev_detector;

  localparam int SW = 8;
  localparam int HR = 4;
  localparam int CW = 8;
  localparam int AW = SW + HR;

  typedef struct packed {
    logic [SW-1:0] m;
    logic [SW-1:0] r;
    logic          v;
    logic          det;
    logic [CW-1:0] idx;
  } vec_t;

  // threshold 20, no length limit
  localparam vec_t VECS [6] = '{
    '{8'd10,  8'd8,   1'b1, 1'b0, 8'd0},  // diff 2
    '{8'd5,   8'd9,   1'b1, 1'b0, 8'd0},  // diff -2, negative
    '{8'd100, 8'd0,   1'b0, 1'b0, 8'd0},  // valid low
    '{8'd30,  8'd8,   1'b1, 1'b0, 8'd0},  // diff 20, equal
    '{8'd9,   8'd8,   1'b1, 1'b1, 8'd3},  // diff 21, fires
    '{8'd0,   8'd200, 1'b1, 1'b1, 8'd3}   // ignored after hit
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clear_i, start_i, sample_valid_i;
  logic [SW-1:0] meas_i, ref_i;
  logic [AW-1:0] threshold_i;
  logic [CW-1:0] pattern_total_i;
  logic          busy_o, detected_o, done_o, overflow_o;
  logic [CW-1:0] det_index_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  charge_dev_detector #(.SAMPLE_W(SW), .HEADROOM(HR), .CNT_W(CW)) i_charge_dev_detector (
    .clk             (clk),
    .rst_n           (rst_n),
    .clear_i         (clear_i),
    .start_i         (start_i),
    .sample_valid_i  (sample_valid_i),
    .meas_i          (meas_i),
    .ref_i           (ref_i),
    .threshold_i     (threshold_i),
    .pattern_total_i (pattern_total_i),
    .busy_o          (busy_o),
    .detected_o      (detected_o),
    .done_o          (done_o),
    .overflow_o      (overflow_o),
    .det_index_o     (det_index_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pair(input int m, input int r);
    meas_i = SW'(m);
    ref_i  = SW'(r);
    sample_valid_i = 1'b1;
    @(negedge clk);
    sample_valid_i = 1'b0;
  endtask

  task automatic arm(input int th, input int total);
    threshold_i     = AW'(th);
    pattern_total_i = CW'(total);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic do_clear();
    clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int hit;
    rst_n = 1'b0;
    clear_i = 1'b0; start_i = 1'b0; sample_valid_i = 1'b0;
    meas_i = '0; ref_i = '0; threshold_i = '0; pattern_total_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8 reset state
    check("R8 busy", busy_o, 0);
    check("R8 detected", detected_o, 0);
    check("R8 done", done_o, 0);
    check("R8 overflow", overflow_o, 0);
    check("R8 index", det_index_o, 0);

    // R1 idle pairs are ignored, then R7 arming
    threshold_i = '0;
    pair(200, 0);
    check("R1 idle ignored", {busy_o, detected_o}, 0);
    arm(20, 0);
    check("R7 busy after start", busy_o, 1);

    // table walk: R2 compare, R4 hold
    foreach (VECS[i]) begin
      meas_i = VECS[i].m;
      ref_i  = VECS[i].r;
      sample_valid_i = VECS[i].v;
      @(negedge clk);
      sample_valid_i = 1'b0;
      check($sformatf("R2 vec%0d detected", i), detected_o, VECS[i].det);
      check($sformatf("R4 vec%0d index", i), det_index_o, VECS[i].idx);
      check($sformatf("R9 vec%0d excl", i), busy_o & detected_o, 0);
    end

    // R2 large deviation fires on first pattern
    arm(50, 0);
    pair(200, 0);
    check("R2 large fast detect", detected_o, 1);
    check("R2 large fast index", det_index_o, 0);

    // R2 small deviation accumulates: diff k+1 after pair k
    arm(50, 0);
    hit = -1;
    for (int k = 0; k < 60; k++) begin
      pair(3, 2);
      if (detected_o && hit < 0) hit = k;
    end
    check("R2 slow detect pattern", hit, 50);
    check("R4 slow index", det_index_o, 50);

    // R5 clean finish, then ignore
    arm(100, 3);
    pair(5, 5); pair(5, 5);
    check("R5 not done early", done_o, 0);
    pair(5, 5);
    check("R5 done", done_o, 1);
    check("R5 busy dropped", busy_o, 0);
    pair(255, 0);
    check("R4 post-done ignored", {detected_o, done_o}, 1);

    // R5 detection on last pattern wins
    arm(0, 2);
    pair(1, 1);
    pair(2, 1);
    check("R5 last hit detected", detected_o, 1);
    check("R5 last hit not done", done_o, 0);
    check("R5 last hit index", det_index_o, 1);

    // R3 saturation
    arm(4095, 0);
    for (int k = 0; k < 16; k++) pair(255, 0);
    check("R3 no overflow at 4080", overflow_o, 0);
    check("R2 max threshold never fires", detected_o, 0);
    pair(255, 0);
    check("R3 overflow set", overflow_o, 1);
    threshold_i = AW'(4094);
    pair(0, 0);
    check("R3 held at full scale", detected_o, 1);
    check("R3 saturated index", det_index_o, 17);
    check("R3 overflow sticky", overflow_o, 1);

    // R7 start clears flags
    arm(10, 0);
    check("R7 overflow cleared", overflow_o, 0);
    check("R7 detected cleared", detected_o, 0);

    // R6 clear beats start
    clear_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0; start_i = 1'b0;
    check("R6 clear priority", busy_o, 0);
    pair(255, 0);
    check("R1 ignored after clear", detected_o, 0);

    // R6 clear after detection
    arm(0, 0);
    pair(9, 0);
    check("R6 pre-clear hit", detected_o, 1);
    do_clear();
    check("R6 detected cleared", detected_o, 0);
    check("R6 index cleared", det_index_o, 0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule